// File: doc/BRIEF.md
# I2C FIFO Threshold Event Generator

This block sits between a host register port and the bit engine of a byte-oriented I2C master. It holds a transmit byte FIFO and a receive byte FIFO, and a transfer length counter. The host fills the transmit FIFO and empties the receive FIFO through a data register. The bit engine takes bytes from the transmit side and delivers bytes to the receive side through a push/pop port. Each byte the engine moves is subtracted from the remaining transfer count.

Four level outputs tell the host when to act. A "ready" event means a FIFO has crossed its programmed threshold, so a full burst of threshold size can be moved. A "draining" event means the bytes left in the transfer are too few ever to reach the threshold. The host then moves the final partial burst without waiting for a threshold crossing that cannot come. Each event is a function of registered state only, so it is valid from the cycle after the clock edge that changed that state.

Top module: `i2c_fifo_evt`

## Requirements
- R1: After reset both FIFOs are empty, the remaining count is 0, both threshold fields are 0, all sticky flags are 0 and all four events are low.
- R2: Register 0 (control) holds the transmit threshold minus one in bits 5:0 and the receive threshold minus one in bits 13:8. A read returns those fields with every other bit 0, including the clear bits 6 and 14.
- R3: Writing control with bit 6 set empties the transmit FIFO and clears its two sticky flags. Bit 14 does the same for the receive FIFO. A clear wins over a push, a pop or an engine move on that FIFO in the same cycle.
- R4: Writing a non-zero value to register 1 (count) loads the remaining transfer count. Writing zero is ignored. A read of register 1 returns the remaining count.
- R5: The remaining count falls by one for each byte the engine actually moves (a transmit pop from a non-empty FIFO, or a receive push into a non-full FIFO). It never goes below zero.
- R6: Both FIFOs are first-in first-out. A write to register 2 pushes the low byte onto the transmit FIFO. A read of register 2 returns the receive head and pops it. A read of an empty receive FIFO returns 0, and the engine sees 0 on the transmit data port when that FIFO is empty.
- R7: A push to a full FIFO or a pop from an empty FIFO leaves the FIFO unchanged and sets a sticky flag. Register 3 holds these flags: bit 3 transmit overflow, bit 4 transmit underflow, bit 5 receive overflow, bit 6 receive underflow.
- R8: rx_ready is high exactly when the receive level is at least the receive threshold.
- R9: rx_drain is high exactly when the remaining count is 0 and the receive level is non-zero but below the threshold.
- R10: Let need be the remaining count minus the transmit level, floored at 0. tx_ready is high exactly when the transmit level is below the transmit threshold and need is at least the threshold.
- R11: tx_drain is high exactly when the transmit level is below the threshold and need is non-zero but below the threshold.
- R12: Register 3 bits 2:0 read the depth code, with FIFO depth equal to 8 shifted left by the code. All bits of register 3 other than the code and the flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO when the data register is addressed) |
| reg_addr | input | 2 | Register select: 0 control, 1 count, 2 data, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register, combinational |
| eng_tx_pop | input | 1 | Bit engine takes one transmit byte |
| eng_tx_data | output | 8 | Transmit FIFO head, 0 when empty |
| eng_rx_push | input | 1 | Bit engine delivers one receive byte |
| eng_rx_data | input | 8 | Receive byte from the bit engine |
| tx_ready | output | 1 | Transmit threshold event |
| tx_drain | output | 1 | Transmit final partial burst event |
| rx_ready | output | 1 | Receive threshold event |
| rx_drain | output | 1 | Receive final partial burst event |

## Verification
Read data and the engine's transmit byte are combinational views of the current state. The bench checks them after inputs settle, before the edge that acts on the strobe. FIFO contents, the count, the flags and the four events change at that edge. The bench compares all of them at the following falling edge against a reference model it updates at the same edge. Directed corner cases are mixed with a seeded random run in which every cycle's events and every read are compared.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
   typedef enum logic [1:0] {
      RA_CTRL   = 2'd0,
      RA_COUNT  = 2'd1,
      RA_DATA   = 2'd2,
      RA_STATUS = 2'd3
   } reg_addr_e;

   localparam int THR_W      = 6;
   localparam int TXTHR_LSB  = 0;
   localparam int RXTHR_LSB  = 8;
   localparam int TXCLR_BIT  = 6;
   localparam int RXCLR_BIT  = 14;
   localparam int CODE_W     = 3;
   localparam int ST_TXOVF   = 3;
   localparam int ST_TXUNF   = 4;
   localparam int ST_RXOVF   = 5;
   localparam int ST_RXUNF   = 6;
endpackage

// File: rtl/i2cfe_fifo.sv
module i2cfe_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [LW-1:0] level,
   output logic          push_acc,
   output logic          pop_acc,
   output logic          ovf,
   output logic          unf
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("i2cfe_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          full, empty;

   assign full     = (level == LW'(DEPTH));
   assign empty    = (level == '0);
   assign push_acc = push && !full && !clr;
   assign pop_acc  = pop && !empty && !clr;
   assign head     = empty ? '0 : mem[rp];

   always_ff @(posedge clk) begin
      if (push_acc) mem[wp] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
         ovf   <= 1'b0;
         unf   <= 1'b0;
      end else begin
         if (push_acc) wp <= wp + 1'b1;
         if (pop_acc)  rp <= rp + 1'b1;
         level <= level + LW'(push_acc) - LW'(pop_acc);
         if (push && full) ovf <= 1'b1;
         if (pop && empty) unf <= 1'b1;
      end
   end
endmodule

// File: rtl/i2cfe_xfer_cnt.sv
module i2cfe_xfer_cnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          mv_a,
   input  logic          mv_b,
   output logic [CW-1:0] rem
);
   logic [CW-1:0] dec;
   assign dec = CW'(mv_a) + CW'(mv_b);

   always_ff @(posedge clk) begin
      if (!rst_n)
         rem <= '0;
      else if (load && load_val != '0)
         rem <= load_val;
      else if (rem > dec)
         rem <= rem - dec;
      else
         rem <= '0;
   end
endmodule

// File: rtl/i2cfe_evt.sv
module i2cfe_evt #(
   parameter int LW    = 5,
   parameter int CW    = 16,
   parameter int THR_W = 6
) (
   input  logic [LW-1:0]    tx_lvl,
   input  logic [LW-1:0]    rx_lvl,
   input  logic [CW-1:0]    rem,
   input  logic [THR_W-1:0] tx_thr_m1,
   input  logic [THR_W-1:0] rx_thr_m1,
   output logic             tx_ready,
   output logic             tx_drain,
   output logic             rx_ready,
   output logic             rx_drain
);
   localparam int EW = CW + 1;

   logic [EW-1:0] tthr, rthr, tl, rl, rm, need;
   logic          tx_below;

   assign tthr     = EW'(tx_thr_m1) + 1'b1;
   assign rthr     = EW'(rx_thr_m1) + 1'b1;
   assign tl       = EW'(tx_lvl);
   assign rl       = EW'(rx_lvl);
   assign rm       = EW'(rem);
   assign need     = (rm > tl) ? rm - tl : '0;
   assign tx_below = tl < tthr;

   assign tx_ready = tx_below && (need >= tthr);
   assign tx_drain = tx_below && (need != '0) && (need < tthr);
   assign rx_ready = rl >= rthr;
   assign rx_drain = !rx_ready && (rl != '0) && (rm == '0);
endmodule

// File: rtl/i2c_fifo_evt.sv
module i2c_fifo_evt
   import i2cfe_pkg::*;
#(
   parameter int DEPTH_CODE = 1,
   parameter int DW         = 8,
   parameter int CW         = 16,
   parameter int RW         = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   input  logic          eng_tx_pop,
   output logic [DW-1:0] eng_tx_data,
   input  logic          eng_rx_push,
   input  logic [DW-1:0] eng_rx_data,
   output logic          tx_ready,
   output logic          tx_drain,
   output logic          rx_ready,
   output logic          rx_drain
);
   localparam int DEPTH = 8 << DEPTH_CODE;
   localparam int AW    = $clog2(DEPTH);
   localparam int LW    = AW + 1;

   generate
      if (DEPTH_CODE < 0 || DEPTH_CODE > 3) begin : g_bad_code
         $error("i2c_fifo_evt: DEPTH_CODE must be 0..3");
      end
      if (CW > RW || DW > RW || CW <= THR_W) begin : g_bad_width
         $error("i2c_fifo_evt: width parameters inconsistent");
      end
      if (RW <= RXCLR_BIT) begin : g_bad_rw
         $error("i2c_fifo_evt: register width too small");
      end
   endgenerate

   reg_addr_e     ra;
   logic          ctrl_wr, cnt_wr, data_wr, data_rd, tx_clr, rx_clr;
   logic [THR_W-1:0] tx_thr_m1, rx_thr_m1;
   logic [CW-1:0] rem_q;
   logic [LW-1:0] tx_lvl, rx_lvl;
   logic [DW-1:0] rx_head;
   logic          tx_pop_acc, rx_push_acc;
   logic          tx_push_acc_n, rx_pop_acc_n;
   logic          tx_ovf, tx_unf, rx_ovf, rx_unf;

   assign ra      = reg_addr_e'(reg_addr);
   assign ctrl_wr = reg_wr && ra == RA_CTRL;
   assign cnt_wr  = reg_wr && ra == RA_COUNT;
   assign data_wr = reg_wr && ra == RA_DATA;
   assign data_rd = reg_rd && ra == RA_DATA;
   assign tx_clr  = ctrl_wr && reg_wdata[TXCLR_BIT];
   assign rx_clr  = ctrl_wr && reg_wdata[RXCLR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_thr_m1 <= '0;
         rx_thr_m1 <= '0;
      end else if (ctrl_wr) begin
         tx_thr_m1 <= reg_wdata[TXTHR_LSB +: THR_W];
         rx_thr_m1 <= reg_wdata[RXTHR_LSB +: THR_W];
      end
   end

   i2cfe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(data_wr), .push_data(reg_wdata[DW-1:0]),
      .pop(eng_tx_pop), .head(eng_tx_data), .level(tx_lvl),
      .push_acc(tx_push_acc_n), .pop_acc(tx_pop_acc),
      .ovf(tx_ovf), .unf(tx_unf)
   );

   i2cfe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(eng_rx_push), .push_data(eng_rx_data),
      .pop(data_rd), .head(rx_head), .level(rx_lvl),
      .push_acc(rx_push_acc), .pop_acc(rx_pop_acc_n),
      .ovf(rx_ovf), .unf(rx_unf)
   );

   i2cfe_xfer_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_wr),
      .load_val(reg_wdata[CW-1:0]),
      .mv_a(tx_pop_acc), .mv_b(rx_push_acc), .rem(rem_q)
   );

   i2cfe_evt #(.LW(LW), .CW(CW), .THR_W(THR_W)) u_evt (
      .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .rem(rem_q),
      .tx_thr_m1(tx_thr_m1), .rx_thr_m1(rx_thr_m1),
      .tx_ready(tx_ready), .tx_drain(tx_drain),
      .rx_ready(rx_ready), .rx_drain(rx_drain)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (ra)
         RA_CTRL: begin
            reg_rdata[TXTHR_LSB +: THR_W] = tx_thr_m1;
            reg_rdata[RXTHR_LSB +: THR_W] = rx_thr_m1;
         end
         RA_COUNT:  reg_rdata = RW'(rem_q);
         RA_DATA:   reg_rdata = RW'(rx_head);
         RA_STATUS: begin
            reg_rdata[CODE_W-1:0] = CODE_W'(DEPTH_CODE);
            reg_rdata[ST_TXOVF]   = tx_ovf;
            reg_rdata[ST_TXUNF]   = tx_unf;
            reg_rdata[ST_RXOVF]   = rx_ovf;
            reg_rdata[ST_RXUNF]   = rx_unf;
         end
         default: reg_rdata = '0;
      endcase
   end

   logic unused_acc;
   assign unused_acc = tx_push_acc_n ^ rx_pop_acc_n;
endmodule

// File: rtl/i2cfe_chk.sv
module i2cfe_chk #(
   parameter int CW = 16,
   parameter int LW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cnt_wr,
   input logic          tx_clr,
   input logic          rx_clr,
   input logic [CW-1:0] rem,
   input logic [LW-1:0] tx_lvl,
   input logic [LW-1:0] rx_lvl,
   input logic          tx_ovf,
   input logic          rx_unf,
   input logic          tx_ready,
   input logic          tx_drain,
   input logic          rx_ready,
   input logic          rx_drain
);
   // R5
   rem_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> rem <= $past(rem));
   // R5
   rem_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && rem == '0) |=> rem == '0);
   // R3
   tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr |=> tx_lvl == '0);
   // R3
   rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr |=> rx_lvl == '0);
   // R7
   tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !tx_clr) |=> tx_ovf);
   // R7
   rx_unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_unf && !rx_clr) |=> rx_unf);
   // R9
   rx_drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drain |-> (rem == '0 && rx_lvl != '0 && !rx_ready));
   // R11
   tx_evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({tx_ready, tx_drain}) <= 1);
   // R10
   tx_ready_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> rem != '0);
endmodule

bind i2c_fifo_evt i2cfe_chk #(.CW(CW), .LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .tx_clr(tx_clr),
   .rx_clr(rx_clr), .rem(rem_q), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
   .tx_ovf(tx_ovf), .rx_unf(rx_unf), .tx_ready(tx_ready),
   .tx_drain(tx_drain), .rx_ready(rx_ready), .rx_drain(rx_drain)
);

// File: tb/i2c_fifo_evt_bench.sv
module i2c_fifo_evt_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DCODE      = 1;
   localparam int DEPTH      = 8 << DCODE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
   logic [7:0]  eng_tx_data, eng_rx_data = '0;
   logic        tx_ready, tx_drain, rx_ready, rx_drain;

   int n_checks = 0, n_fail = 0;
   bit finished = 1'b0;

   logic [5:0]  m_txthr, m_rxthr;
   int unsigned m_rem;
   logic [7:0]  tx_q[$], rx_q[$];
   bit          m_txovf, m_txunf, m_rxovf, m_rxunf;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_fifo_evt #(.DEPTH_CODE(DCODE)) u_i2c_fifo_evt (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .tx_ready(tx_ready), .tx_drain(tx_drain),
      .rx_ready(rx_ready), .rx_drain(rx_drain)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_rdata(input logic [1:0] a);
      case (a)
         2'd0: return {2'b0, m_rxthr, 2'b0, m_txthr};
         2'd1: return m_rem[15:0];
         2'd2: return (rx_q.size() > 0) ? {8'h0, rx_q[0]} : 16'h0;
         default: return {9'b0, m_rxunf, m_rxovf, m_txunf, m_txovf, 3'(DCODE)};
      endcase
   endfunction

   function automatic string addr_tag(input logic [1:0] a);
      case (a)
         2'd0: return "R2";
         2'd1: return "R4";
         2'd2: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [3:0] exp_evt();
      int tthr = m_txthr + 1;
      int rthr = m_rxthr + 1;
      int tl = tx_q.size();
      int rl = rx_q.size();
      int need = (int'(m_rem) > tl) ? int'(m_rem) - tl : 0;
      logic tr, td, rr, rd;
      tr = (tl < tthr) && (need >= tthr);
      td = (tl < tthr) && (need > 0) && (need < tthr);
      rr = (rl >= rthr);
      rd = !rr && (rl > 0) && (m_rem == 0);
      return {tr, td, rr, rd};
   endfunction

   task automatic model_reset();
      m_txthr = '0; m_rxthr = '0; m_rem = 0;
      tx_q.delete(); rx_q.delete();
      m_txovf = 0; m_txunf = 0; m_rxovf = 0; m_rxunf = 0;
   endtask

   task automatic model_step(input bit wr, input bit rd, input logic [1:0] a,
                             input logic [15:0] d, input bit ep, input bit eu,
                             input logic [7:0] ed);
      int txn = tx_q.size();
      int rxn = rx_q.size();
      bit ctrlw = wr && a == 2'd0;
      bit ctx = ctrlw && d[6];
      bit crx = ctrlw && d[14];
      bit hpush = wr && a == 2'd2;
      bit hpop = rd && a == 2'd2;
      bit txmv = ep && txn > 0 && !ctx;
      bit rxmv = eu && rxn < DEPTH && !crx;
      int dec = int'(txmv) + int'(rxmv);
      if (wr && a == 2'd1 && d != 0) m_rem = d;
      else m_rem = (m_rem > dec) ? m_rem - dec : 0;
      if (ctx) begin
         tx_q.delete(); m_txovf = 0; m_txunf = 0;
      end else begin
         if (hpush && txn == DEPTH) m_txovf = 1;
         if (ep && txn == 0) m_txunf = 1;
         if (txmv) void'(tx_q.pop_front());
         if (hpush && txn < DEPTH) tx_q.push_back(d[7:0]);
      end
      if (crx) begin
         rx_q.delete(); m_rxovf = 0; m_rxunf = 0;
      end else begin
         if (eu && rxn == DEPTH) m_rxovf = 1;
         if (hpop && rxn == 0) m_rxunf = 1;
         if (hpop && rxn > 0) void'(rx_q.pop_front());
         if (rxmv) rx_q.push_back(ed);
      end
      if (ctrlw) begin
         m_txthr = d[5:0];
         m_rxthr = d[13:8];
      end
   endtask

   // One cycle: drive at a falling edge, check combinational views, take the
   // edge, update the model, check registered results at the next falling edge.
   task automatic cyc(input bit wr, input bit rd, input logic [1:0] a,
                      input logic [15:0] d, input bit ep, input bit eu,
                      input logic [7:0] ed, input string tag = "");
      logic [3:0] ev;
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
      eng_tx_pop = ep; eng_rx_push = eu; eng_rx_data = ed;
      #1;
      if (rd) check((tag != "") ? tag : addr_tag(a), 32'(reg_rdata), 32'(exp_rdata(a)));
      if (ep) check("R6", 32'(eng_tx_data), (tx_q.size() > 0) ? 32'(tx_q[0]) : 32'h0);
      @(posedge clk);
      model_step(wr, rd, a, d, ep, eu, ed);
      @(negedge clk);
      ev = exp_evt();
      check("R10", 32'(tx_ready), 32'(ev[3]));
      check("R11", 32'(tx_drain), 32'(ev[2]));
      check("R8",  32'(rx_ready), 32'(ev[1]));
      check("R9",  32'(rx_drain), 32'(ev[0]));
      reg_wr = 0; reg_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
      cyc(1, 0, a, d, 0, 0, 8'h0);
   endtask
   task automatic rd_reg(input logic [1:0] a, input string tag = "");
      cyc(0, 1, a, 16'h0, 0, 0, 8'h0, tag);
   endtask
   task automatic eng(input bit ep, input bit eu, input logic [7:0] ed);
      cyc(0, 0, 2'd0, 16'h0, ep, eu, ed);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired: actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1c2f1f0));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", {28'h0, tx_ready, tx_drain, rx_ready, rx_drain}, 32'h0);
      rd_reg(2'd0, "R1");
      rd_reg(2'd1, "R1");
      rd_reg(2'd3, "R12");
      check("R12", 32'(u_i2c_fifo_evt.reg_rdata[2:0] & 3'h0), 32'h0);
      // R4: zero length ignored
      wr_reg(2'd1, 16'd9);
      wr_reg(2'd1, 16'd0);
      rd_reg(2'd1, "R4");
      check("R4", m_rem, 9);
      // R11 / R10: thresholds 5 (tx) and 4 (rx)
      wr_reg(2'd0, 16'h0304);
      wr_reg(2'd1, 16'd3);
      check("R11", 32'(tx_drain), 32'h1);
      wr_reg(2'd1, 16'd12);
      check("R10", 32'(tx_ready), 32'h1);
      for (int i = 0; i < 8; i++) wr_reg(2'd2, 16'(8'hA0 + i));
      for (int i = 0; i < 4; i++) eng(1, 0, 8'h0);
      check("R11", 32'(tx_drain), 32'h1);
      // R3: clear both, thresholds kept
      wr_reg(2'd0, 16'h4344);
      rd_reg(2'd2, "R3");
      rd_reg(2'd0, "R2");
      // RX path
      wr_reg(2'd1, 16'd6);
      for (int i = 0; i < 4; i++) eng(0, 1, 8'(8'h30 + i));
      check("R8", 32'(rx_ready), 32'h1);
      for (int i = 0; i < 4; i++) rd_reg(2'd2, "R6");
      eng(0, 1, 8'h55); eng(0, 1, 8'h66);
      check("R9", 32'(rx_drain), 32'h1);
      eng(0, 1, 8'h77);
      rd_reg(2'd1, "R5");
      // R7: overflow and underflow
      wr_reg(2'd0, 16'h4344);
      wr_reg(2'd1, 16'd40);
      for (int i = 0; i < DEPTH + 1; i++) wr_reg(2'd2, 16'(i + 1));
      rd_reg(2'd3, "R7");
      for (int i = 0; i < DEPTH + 1; i++) eng(1, 0, 8'h0);
      rd_reg(2'd3, "R7");
      rd_reg(2'd2, "R7");
      rd_reg(2'd3, "R7");
      // R8: threshold above depth never ready
      wr_reg(2'd0, 16'h7F44);
      wr_reg(2'd1, 16'd40);
      for (int i = 0; i < DEPTH + 1; i++) eng(0, 1, 8'(i));
      check("R8", 32'(rx_ready), 32'h0);
      rd_reg(2'd3, "R7");
      // seeded random mix
      for (int n = 0; n < 4000; n++) begin
         int r = $urandom % 100;
         bit wr = 0, rd = 0;
         logic [1:0] a = 2'($urandom % 4);
         logic [15:0] d = 16'($urandom);
         if (r < 6) begin
            a = 2'd0;
            d = {1'b0, ($urandom % 10 == 0), 6'($urandom % 8), 1'b0,
                 ($urandom % 10 == 0), 6'($urandom % 8)};
            wr = 1;
         end else if (r < 12) begin
            a = 2'd1; d = 16'($urandom % 30); wr = 1;
         end else if (r < 40) begin
            a = 2'd2; wr = 1;
         end else if (r < 75) begin
            rd = 1;
         end
         cyc(wr, rd, a, d, ($urandom % 100) < 30, ($urandom % 100) < 30,
             8'($urandom));
      end
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule